// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Edge Interrupts

The block controls eight pads. Each pad can serve as a plain input or output, be handed to a peripheral, or be given to a capacitive-sense oscillator. The selection is made per pin by two select bits.

A small byte-wide register bus reads and writes the configuration. Writes take effect at the clock edge. Reads are combinational, from the address.

Every pad input is resynchronised before use. Each pin has a flag that latches a rising or falling transition, and software can set or clear that flag directly. One interrupt line gathers all enabled flags.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is 0, `osc_sel` is 0 and `irq` is 0.
- R2: The register offsets are as follows:
  - Offset 1: output value.
  - Offset 2: direction (1 = output).
  - Offset 3: flag.
  - Offset 4: edge select.
  - Offset 5: interrupt enable.
  - Offset 6: function select.
  - Offset 7: pull enable.
  - Offset 8: second select.
  - Offset 0: synchronised input. It is read-only, and a write to it has no effect.
  - Any other offset reads 0.
  - Every writable register reads back the value written, one clock edge after the write.
- R3: The input register shows a pad change two rising clock edges after the change.
- R4: With both select bits 0, the pin drives its output bit, and `pad_oe` equals its direction bit.
- R5: With select 1 and second select 0, the pin is in peripheral mode:
  - Direction 1 drives `alt_out` onto the pad.
  - Direction 0 routes the synchronised pad value to `alt_in`, and `pad_oe` is 0.
  - In all other modes, `alt_in` is 0.
- R6: With second select 1, the pin is in oscillator mode, whatever the select bit is. In this mode `osc_sel` is 1, and `pad_oe` is 0 whatever the direction bit is.
- R7: The pull resistor setting works as follows:
  - `pad_pull_en` is set when the pull-enable bit is 1 and the pin is not driving.
  - `pad_pull_up` follows the output bit: 1 means pull-up, 0 means pull-down.
- R8: A pin's flag sets on the edge chosen by its edge-select bit (0 = rising, 1 = falling). The flag sets on the third rising clock edge after the pad change, whatever the interrupt enable is.
- R9: A write to the flag register both sets and clears bits. When a hardware edge and a clearing write fall in the same cycle, the flag ends up set.
- R10: `irq` is the OR, over all pins, of flag AND enable. It follows the registers with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enable |
| pad_pull_en | output | 8 | Pull resistor enable |
| pad_pull_up | output | 8 | Pull direction, 1 = up |
| alt_out | input | 8 | Peripheral output per pin |
| alt_in | output | 8 | Pad value routed to the peripheral |
| osc_sel | output | 8 | Pin handed to the oscillator |
| irq | output | 1 | Port interrupt |

## Verification
Results fall due at three different times after a stimulus:
- Register writes, and the pad controls derived from them, are due one rising edge after the strobe.
- The input register and `alt_in` are due two rising edges after a pad change.
- Flags and `irq` are due three rising edges after a pad change.

The bench drives and samples on falling edges, so it counts these edges exactly. For timing, it checks a flag both one edge early, where the flag must still be clear, and on time, where it must be set. For the race case, the bench places the clearing write in exactly the cycle in which the edge is detected.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8,
  parameter int AW = 4,
  parameter logic [AW-1:0] SEL2_OFS = 4'h8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_we,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pull_en,
  output logic [W-1:0]  pad_pull_up,
  input  logic [W-1:0]  alt_out,
  output logic [W-1:0]  alt_in,
  output logic [W-1:0]  osc_sel,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_IN   = AW'(0);
  localparam logic [AW-1:0] OFS_OUT  = AW'(1);
  localparam logic [AW-1:0] OFS_DIR  = AW'(2);
  localparam logic [AW-1:0] OFS_FLAG = AW'(3);
  localparam logic [AW-1:0] OFS_EDGE = AW'(4);
  localparam logic [AW-1:0] OFS_IE   = AW'(5);
  localparam logic [AW-1:0] OFS_SEL  = AW'(6);
  localparam logic [AW-1:0] OFS_REN  = AW'(7);

  logic [W-1:0] out_r, dir_r, flag_r, edge_r, ie_r, sel_r, sel2_r, ren_r;
  logic [W-1:0] sync1, sync2, last;
  logic [W-1:0] hit, periph;
  logic [1:0]   since_rst;

  function automatic logic wr_at(input logic [AW-1:0] a);
    return bus_we && (bus_addr == a);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      last  <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      last  <= sync2;
    end
  end

  assign hit = (~edge_r & sync2 & ~last) | (edge_r & ~sync2 & last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_r  <= '0;
      dir_r  <= '0;
      flag_r <= '0;
      edge_r <= '0;
      ie_r   <= '0;
      sel_r  <= '0;
      sel2_r <= '0;
      ren_r  <= '0;
    end else begin
      if (wr_at(OFS_OUT))  out_r  <= bus_wdata;
      if (wr_at(OFS_DIR))  dir_r  <= bus_wdata;
      if (wr_at(OFS_EDGE)) edge_r <= bus_wdata;
      if (wr_at(OFS_IE))   ie_r   <= bus_wdata;
      if (wr_at(OFS_SEL))  sel_r  <= bus_wdata;
      if (wr_at(SEL2_OFS)) sel2_r <= bus_wdata;
      if (wr_at(OFS_REN))  ren_r  <= bus_wdata;
      flag_r <= (wr_at(OFS_FLAG) ? bus_wdata : flag_r) | hit;
    end
  end

  assign periph      = sel_r & ~sel2_r;
  assign osc_sel     = sel2_r;
  assign pad_oe      = dir_r & ~sel2_r;
  assign pad_out     = (periph & alt_out) | (~periph & out_r);
  assign alt_in      = periph & ~dir_r & sync2;
  assign pad_pull_en = ren_r & ~pad_oe;
  assign pad_pull_up = out_r;
  assign irq         = |(flag_r & ie_r);

  always_comb begin
    case (bus_addr)
      OFS_IN:   bus_rdata = sync2;
      OFS_OUT:  bus_rdata = out_r;
      OFS_DIR:  bus_rdata = dir_r;
      OFS_FLAG: bus_rdata = flag_r;
      OFS_EDGE: bus_rdata = edge_r;
      OFS_IE:   bus_rdata = ie_r;
      OFS_SEL:  bus_rdata = sel_r;
      OFS_REN:  bus_rdata = ren_r;
      SEL2_OFS: bus_rdata = sel2_r;
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_FLAG_SETS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (|hit) |=> ((flag_r & $past(hit)) == $past(hit))); // R8
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!wr_at(OFS_FLAG) && hit == '0) |=> $stable(flag_r)); // R9
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_at(OFS_DIR) |=> (dir_r == $past(bus_wdata))); // R2
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n) (since_rst == 2'd3) |-> (sync2 == $past(pad_in, 2))); // R3
  AST_PULL_DIR: assert property (@(posedge clk) disable iff (!rst_n) wr_at(OFS_OUT) |=> (pad_pull_up == $past(bus_wdata))); // R7
endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata, pad_in = '0, pad_out, pad_oe, pad_pull_en, pad_pull_up;
  logic [7:0] alt_out = '0, alt_in, osc_sel;
  logic       irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
    .alt_out(alt_out), .alt_in(alt_in), .osc_sel(osc_sel), .irq(irq)
  );

  // {addr, write data, expected read-back}
  localparam logic [19:0] VEC [12] = '{
    {4'h1, 8'hA5, 8'hA5}, {4'h2, 8'h3C, 8'h3C}, {4'h4, 8'hF0, 8'hF0},
    {4'h5, 8'h0F, 8'h0F}, {4'h6, 8'h81, 8'h81}, {4'h7, 8'h42, 8'h42},
    {4'h8, 8'h18, 8'h18}, {4'h0, 8'hFF, 8'h00}, {4'h9, 8'h77, 8'h00},
    {4'hF, 8'hEE, 8'h00}, {4'h3, 8'h55, 8'h55}, {4'h3, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pad_in = '0; alt_out = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    for (int a = 0; a < 16; a++) rd("R1 reset read", 4'(a), 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 osc_sel", osc_sel, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 table walk
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd("R2 readback", VEC[i][19:16], VEC[i][7:0]);
    end

    // R4 R7 GPIO mode
    do_reset();
    wr(4'h2, 8'h0F); wr(4'h1, 8'hA5); wr(4'h7, 8'hFF);
    #1;
    chk("R4 pad_oe", pad_oe, 8'h0F);
    chk("R4 pad_out", pad_out, 8'hA5);
    chk("R7 pull_en", pad_pull_en, 8'hF0);
    chk("R7 pull_up", pad_pull_up, 8'hA5);

    // R5 peripheral mode
    alt_out = 8'h33;
    wr(4'h6, 8'hFF);
    #1;
    chk("R5 pad_out", pad_out & 8'h0F, 8'h03);
    chk("R5 pad_oe", pad_oe, 8'h0F);
    @(negedge clk);
    pad_in = 8'hC0;
    repeat (2) @(negedge clk);
    chk("R5 alt_in", alt_in, 8'hC0);

    // R6 oscillator mode, direction ignored
    wr(4'h2, 8'hFF); wr(4'h8, 8'hF0);
    #1;
    chk("R6 osc_sel", osc_sel, 8'hF0);
    chk("R6 pad_oe", pad_oe, 8'h0F);
    chk("R5 alt_in off", alt_in, 8'h00);

    // R3 R8 R10 edges
    do_reset();
    wr(4'h4, 8'hF0);
    pad_in = 8'hFF;
    repeat (2) @(negedge clk);
    rd("R3 input after two edges", 4'h0, 8'hFF);
    rd("R8 flag not yet", 4'h3, 8'h00);
    @(negedge clk);
    rd("R8 rising flags", 4'h3, 8'h0F);
    chk("R10 irq disabled", {7'b0, irq}, 8'h00);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    rd("R8 falling flags", 4'h3, 8'hFF);
    wr(4'h5, 8'h10);
    chk("R10 irq on", {7'b0, irq}, 8'h01);
    wr(4'h3, 8'h00);
    rd("R9 cleared", 4'h3, 8'h00);
    chk("R10 irq off", {7'b0, irq}, 8'h00);
    wr(4'h3, 8'h81);
    rd("R9 set by write", 4'h3, 8'h81);
    chk("R10 irq masked", {7'b0, irq}, 8'h00);
    wr(4'h5, 8'h80);
    chk("R10 irq bit7", {7'b0, irq}, 8'h01);

    // R9 race: clearing write in the detection cycle
    wr(4'h3, 8'h00);
    pad_in = 8'h01;
    repeat (2) @(negedge clk);
    wr(4'h3, 8'h00);
    rd("R9 edge beats clear", 4'h3, 8'h01);
    wr(4'h3, 8'h00);
    rd("R9 later clear", 4'h3, 8'h00);

    done = 1;
    finish_run();
  end
endmodule